// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives an external controller read and write access to a small file of 8-bit configuration registers. The controller frames each access with five signals: an active-low select, a serial clock, an address strobe, a read/write direction line and one data line. Each access carries an 8-bit register address and then 8 data bits. Both fields are sent most significant bit first. The address strobe is high while the address bits are sent and low while the data bits are sent. The data line is sampled on rising serial-clock edges.

The serial clock has no fixed phase relation to the core clock. All five serial inputs pass through multi-flop synchronizers. The block then finds serial-clock edges by oversampling them in the core domain, so the serial clock may run at no more than half the core clock. On a read, the block drives the selected register onto the data line, starting at the first serial-clock falling edge after the address is complete. The data line is split into a value output and an output enable for the pad. The whole register file is available to the core as a flat vector. The core reset clears only the framing logic. Register contents are never reset.

Top module: `sercfg_port`

## Requirements
- R1: A write is an access with the direction line low. It stores the 8 data bits in the register whose index is the 8-bit address, with both fields received MSB first on rising serial-clock edges. Register k appears on `cfg_flat[8k+7:8k]`.
- R2: A read is an access with the direction line high. On the data line it presents the addressed register MSB first. The first bit is valid from the first serial-clock falling edge after the eighth address bit, and each later falling edge moves to the next bit.
- R3: The data-line output enable is low in any cycle in which select is high or the direction line is low.
- R4: While select is high, activity on the serial clock, data, strobe and direction lines changes no register.
- R5: Asserting the core reset leaves every register value unchanged.
- R6: After reset, with select high, the data-line output enable is low.
- R7: A write to an address at or above the register count changes no register. A read from such an address returns all zeros.
- R8: If select is released before the eighth data bit, the write does not take effect, and the next access decodes from a fresh address phase.
- R9: While select stays low, raising the strobe again after a data phase starts a new access, so two writes can share one select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low core reset, clears framing state only |
| ser_cs_n | input | 1 | Active-low port select |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_as | input | 1 | Address strobe: high for address bits, low for data bits |
| ser_rd | input | 1 | Direction: high read, low write |
| ser_sd_in | input | 1 | Serial data from the pad |
| ser_sd_out | output | 1 | Serial data value driven to the pad on reads |
| ser_sd_oe | output | 1 | Pad output enable for serial data |
| cfg_flat | output | NREG*DATA_W | All registers, register k at bits 8k+7..8k |

## Verification
The bench goes after the alignment of read data against falling edges. A block that loads the read word one edge late, or shifts it on the first edge, puts out the value shifted by one bit, and the full sweep of all 16 addresses catches this. Out-of-range writes are aimed at addresses that alias low registers when only their low bits are decoded. If the range check were dropped, registers 0 and 15 would be overwritten. Aborted writes, frames sent while select is high, and a reset pulse are each followed by a full compare of the register vector, which exposes any stray commit. The enable gating is checked in the middle of an active read by dropping the direction line and then select. An enable taken from the synchronized signals instead of the pins stays high for several cycles and is caught.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
   // order of the serial pins inside the synchronizer vector
   localparam int unsigned PIN_SD   = 0;
   localparam int unsigned PIN_RD   = 1;
   localparam int unsigned PIN_AS   = 2;
   localparam int unsigned PIN_SCLK = 3;
   localparam int unsigned PIN_CSN  = 4;
   localparam int unsigned PIN_CNT  = 5;
   // idle level of the pins: select released, everything else low
   localparam logic [PIN_CNT-1:0] PIN_IDLE = 5'b10000;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sercfg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREG   = 16
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic [NREG*DATA_W-1:0] flat
);
   logic [DATA_W-1:0] regs [NREG];

   // storage has no reset on purpose: core reset must not disturb it
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == ADDR_W'(i))) regs[i] <= wr_data;
      end
      assign flat[i*DATA_W +: DATA_W] = regs[i];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
      end
   end
endmodule

// File: rtl/sercfg_frame.sv
module sercfg_frame #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              as_s,
   input  logic              rd_s,
   input  logic              sd_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              drv_on,
   output logic              drv_bit
);
   localparam int unsigned ACNT_W = $clog2(ADDR_W + 1);
   localparam int unsigned DCNT_W = $clog2(DATA_W + 1);

   logic [ACNT_W-1:0] a_cnt;
   logic [DCNT_W-1:0] d_cnt;
   logic [DATA_W-1:0] rd_sr;
   logic              a_full, d_full;

   assign a_full  = (a_cnt == ACNT_W'(ADDR_W));
   assign d_full  = (d_cnt == DCNT_W'(DATA_W));
   assign drv_bit = rd_sr[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr    <= '0;
         a_cnt   <= '0;
         d_cnt   <= '0;
         wr_data <= '0;
         wr_en   <= 1'b0;
         drv_on  <= 1'b0;
         rd_sr   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (!cs_act) begin
            a_cnt  <= '0;
            d_cnt  <= '0;
            drv_on <= 1'b0;
         end else if (sclk_rise) begin
            if (as_s) begin
               addr   <= {addr[ADDR_W-2:0], sd_s};
               a_cnt  <= a_full ? ACNT_W'(1) : a_cnt + 1'b1;
               d_cnt  <= '0;
               drv_on <= 1'b0;
            end else if (a_full && !d_full) begin
               d_cnt <= d_cnt + 1'b1;
               if (!rd_s) begin
                  wr_data <= {wr_data[DATA_W-2:0], sd_s};
                  if (d_cnt == DCNT_W'(DATA_W - 1)) wr_en <= 1'b1;
               end
            end
         end else if (sclk_fall && a_full && !d_full && rd_s) begin
            if (!drv_on) begin
               drv_on <= 1'b1;
               rd_sr  <= rd_data;
            end else begin
               rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NREG        = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_cs_n,
   input  logic                   ser_clk,
   input  logic                   ser_as,
   input  logic                   ser_rd,
   input  logic                   ser_sd_in,
   output logic                   ser_sd_out,
   output logic                   ser_sd_oe,
   output logic [NREG*DATA_W-1:0] cfg_flat
);
   import sercfg_pkg::*;

   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("sercfg_port: ADDR_W and DATA_W must be at least 2");
   end
   if (NREG < 1 || NREG > (1 << ADDR_W)) begin : g_bad_nreg
      $error("sercfg_port: NREG must fit the address space");
   end

   logic [PIN_CNT-1:0] pins_raw, pins_s;
   logic               sclk_q, cs_n_s, rd_s, sclk_rise, sclk_fall;
   logic               wr_en, drv_on, drv_bit;
   logic [ADDR_W-1:0]  wr_addr;
   logic [DATA_W-1:0]  wr_data, rd_data;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_SD]   = ser_sd_in;
      pins_raw[PIN_RD]   = ser_rd;
      pins_raw[PIN_AS]   = ser_as;
      pins_raw[PIN_SCLK] = ser_clk;
      pins_raw[PIN_CSN]  = ser_cs_n;
   end

   sercfg_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= pins_s[PIN_SCLK];
   end

   assign cs_n_s    = pins_s[PIN_CSN];
   assign rd_s      = pins_s[PIN_RD];
   assign sclk_rise = ~cs_n_s &  pins_s[PIN_SCLK] & ~sclk_q;
   assign sclk_fall = ~cs_n_s & ~pins_s[PIN_SCLK] &  sclk_q;

   sercfg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) frame_i (
      .clk(clk), .rst_n(rst_n), .cs_act(~cs_n_s),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .as_s(pins_s[PIN_AS]), .rd_s(rd_s), .sd_s(pins_s[PIN_SD]),
      .rd_data(rd_data), .addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
      .drv_on(drv_on), .drv_bit(drv_bit)
   );

   sercfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) regs_i (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(wr_addr), .rd_data(rd_data), .flat(cfg_flat)
   );

   // pad enable is gated by the raw pins so release is immediate
   assign ser_sd_out = drv_bit;
   assign ser_sd_oe  = drv_on & ser_rd & ~ser_cs_n;
endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREG   = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ser_cs_n,
   input logic                   ser_rd,
   input logic                   ser_sd_oe,
   input logic                   cs_n_s,
   input logic                   rd_s,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      wr_addr,
   input logic [NREG*DATA_W-1:0] cfg_flat
);
   a_r3_pad_released: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_cs_n || !ser_rd) |-> !ser_sd_oe);

   a_r4_no_commit_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !cs_n_s);

   a_r1_commit_on_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_s);

   a_r7_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr >= ADDR_W'(NREG))) |=> $stable(cfg_flat));

   a_r4_regs_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_flat));
endmodule

bind sercfg_port sercfg_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) chk_i (
   .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_rd(ser_rd),
   .ser_sd_oe(ser_sd_oe), .cs_n_s(cs_n_s), .rd_s(rd_s), .wr_en(wr_en),
   .wr_addr(wr_addr), .cfg_flat(cfg_flat)
);

// File: tb/sercfg_port_tb_top.sv
`timescale 1ns/1ps
module sercfg_port_tb_top;
   localparam int NREG = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_as = 1'b0, ser_rd = 1'b0, ser_sd_in = 1'b0;
   logic ser_sd_out, ser_sd_oe;
   logic [NREG*8-1:0] cfg_flat;
   logic [7:0] model [NREG];
   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sercfg_port dut_i (
      .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
      .ser_as(ser_as), .ser_rd(ser_rd), .ser_sd_in(ser_sd_in),
      .ser_sd_out(ser_sd_out), .ser_sd_oe(ser_sd_oe), .cfg_flat(cfg_flat)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic a, input logic r, input logic d);
      @(negedge clk);
      ser_as = a; ser_rd = r; ser_sd_in = d;
      idle(8); ser_clk = 1'b1;
      idle(8); ser_clk = 1'b0;
   endtask

   task automatic send_addr(input logic [7:0] a, input logic r);
      for (int i = 7; i >= 0; i--) sbit(1'b1, r, a[i]);
   endtask

   task automatic send_wdata(input logic [7:0] d, input int nbits);
      for (int i = 7; i >= 8 - nbits; i--) sbit(1'b0, 1'b0, d[i]);
   endtask

   task automatic select(input logic v);
      @(negedge clk); ser_cs_n = v; idle(8);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      select(1'b0); send_addr(a, 1'b0); send_wdata(d, 8); idle(8); select(1'b1);
   endtask

   task automatic do_read(input logic [7:0] a, input string req, output logic [7:0] got);
      logic oe_all = 1'b1;
      select(1'b0); send_addr(a, 1'b1);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk); ser_as = 1'b0; ser_rd = 1'b1;
         idle(8);
         got[i] = ser_sd_out; oe_all &= ser_sd_oe;
         ser_clk = 1'b1; idle(8); ser_clk = 1'b0;
      end
      check({req, " enable during read"}, {7'd0, oe_all}, 8'd1);
      select(1'b1); ser_rd = 1'b0;
   endtask

   task automatic compare_all(input string req);
      for (int k = 0; k < NREG; k++) check(req, cfg_flat[k*8 +: 8], model[k]);
   endtask

   initial begin
      logic [7:0] got;
      idle(5);
      // R6: reset state
      check("R6 oe in reset", {7'd0, ser_sd_oe}, 8'd0);
      rst_n = 1'b1; idle(5);
      check("R6 oe after reset", {7'd0, ser_sd_oe}, 8'd0);

      // R1: write sweep over every register
      for (int k = 0; k < NREG; k++) begin
         model[k] = 8'((k * 37 + 11) ^ 8'h5A);
         do_write(8'(k), model[k]);
      end
      compare_all("R1 write sweep");

      // R2: read sweep
      for (int k = 0; k < NREG; k++) begin
         do_read(8'(k), "R2", got);
         check("R2 read data", got, model[k]);
      end

      // R7: out-of-range writes aliasing low registers, and reads of zero
      do_write(8'h80, 8'hEE);
      do_write(8'hFF, 8'h11);
      do_write(8'h10, 8'h33);
      compare_all("R7 out-of-range write");
      do_read(8'hC3, "R7", got);
      check("R7 out-of-range read", got, 8'h00);

      // R3: enable gating during a live read
      select(1'b0); send_addr(8'd5, 1'b1);
      @(negedge clk); ser_as = 1'b0; idle(8);
      check("R3 enable on live read", {7'd0, ser_sd_oe}, 8'd1);
      check("R2 first bit", {7'd0, ser_sd_out}, {7'd0, model[5][7]});
      ser_rd = 1'b0; #0.5;
      check("R3 enable with write dir", {7'd0, ser_sd_oe}, 8'd0);
      @(negedge clk); ser_rd = 1'b1; #0.5;
      check("R3 enable restored", {7'd0, ser_sd_oe}, 8'd1);
      @(negedge clk); ser_cs_n = 1'b1; #0.5;
      check("R3 enable with select high", {7'd0, ser_sd_oe}, 8'd0);
      ser_rd = 1'b0; idle(8);
      // R3: enable stays low during a write
      select(1'b0); send_addr(8'd2, 1'b0);
      check("R3 enable on write", {7'd0, ser_sd_oe}, 8'd0);
      send_wdata(8'h3C, 8); idle(8); select(1'b1);
      model[2] = 8'h3C;
      compare_all("R1 write after gating test");

      // R4: full frame with select high
      send_addr(8'd3, 1'b0); send_wdata(8'h00, 8); idle(10);
      compare_all("R4 unselected frame");

      // R5: reset pulse keeps registers
      @(negedge clk); rst_n = 1'b0; idle(4); rst_n = 1'b1; idle(4);
      compare_all("R5 regs across reset");

      // R8: abort after five data bits, then a clean write
      select(1'b0); send_addr(8'd7, 1'b0); send_wdata(8'h81, 5); select(1'b1);
      compare_all("R8 aborted write");
      do_write(8'd8, 8'h96); model[8] = 8'h96;
      compare_all("R8 write after abort");

      // R9: two writes in one select window
      select(1'b0);
      send_addr(8'd9, 1'b0);  send_wdata(8'hA1, 8);
      send_addr(8'd12, 1'b0); send_wdata(8'h4B, 8);
      idle(8); select(1'b1);
      model[9] = 8'hA1; model[12] = 8'h4B;
      compare_all("R9 chained writes");
      do_read(8'd12, "R9", got);
      check("R9 read of chained write", got, 8'h4B);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule